// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block sequences instruction fetch for a small 4-bit controller core. It keeps a program counter made of a page field and a 6-bit in-page address, steps it for ordinary fetch, and redirects it on a computed table branch, on a short subroutine call, and on a return. A four-level return-address stack is held beside the counter. Subroutine calls and interrupt entries both consume stack levels.

A single status flip-flop gates calls. When the flag is set, a call jumps into the page chosen by a preceding page-preload strobe, or into page 0 when no preload came first. When the flag is clear, the call is skipped: it becomes a plain step and the flag is set again. The table branch assembles its target from the accumulator, the B register, the carry flag and two operand bits, and it does not depend on the flag or change it. The decoder drives one strobe per instruction. The ALU can also write the flag directly.

Top module: `prog_seq`

## Requirements
- R1: Reset (rst_n low) clears the counter to 0, every stack level to 0 and the pending page to 0, and sets the status flag to 1.
- R2: A step (inc_en) adds 1 to the address part modulo 64. The page part is unchanged, so address 63 wraps to address 0 of the same page.
- R3: A table branch (tbr_en) loads the address part with {acc, breg[1:0]}, with acc in the upper four bits. It loads the page part with {breg[3:2], opnd[1:0]} OR-ed with carry at page bit 0.
- R4: A table branch is taken whatever the status flag holds, and it leaves the status flag unchanged.
- R5: A call (call_en) taken with status 1 loads the page part from the pending page and the address part from opnd. The pending page then returns to 0.
- R6: A call with status 0 is skipped. The counter steps as in R2, the status flag becomes 1, the stack is unchanged and the pending page returns to 0.
- R7: A taken call pushes the stepped counter (current page, address + 1 mod 64) into level 1 and moves levels 1, 2 and 3 into levels 2, 3 and 4 in the same cycle.
- R8: A push into a full stack drops the value that was in level 4.
- R9: A return (ret_en) loads the counter from level 1 and moves levels 2, 3 and 4 into levels 1, 2 and 3. Level 4 keeps its value.
- R10: A page preload (pgld_en) stores opnd[3:0] as the pending page and steps the counter.
- R11: A status write (st_wr) loads st_val into the flag in any cycle without call_en.
- R12: When strobes coincide, the order of precedence is call, table branch, return, preload, step. With no strobe the counter and stack hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_en | input | 1 | Ordinary fetch step |
| tbr_en | input | 1 | Table branch strobe |
| call_en | input | 1 | Short call strobe |
| ret_en | input | 1 | Return strobe |
| pgld_en | input | 1 | Page preload strobe |
| st_wr | input | 1 | Status write strobe |
| st_val | input | 1 | Status write value |
| opnd | input | 6 | Operand field of the instruction |
| acc | input | 4 | Accumulator |
| breg | input | 4 | B register |
| carry | input | 1 | Carry flag |
| pc_o | output | 10 | Fetch address {page, address} |
| status_o | output | 1 | Status flag |
| stk_o | output | 40 | Stack, level k+1 in bits [10k+9:10k] |

## Verification
The bench builds the block with its default parameters: a 4-bit page, a 4-bit accumulator and a depth of four. At these values five calls in a row fill the stack and then overflow it, and five returns drain it past empty, so both the dropped entry and the retained bottom level can be seen. A six-bit address makes the in-page wrap reachable with a single step from address 63. Every bit of the 4-bit page is reachable, so the OR of carry, B and the operand bits in a table branch, and a far call into a preloaded page, both produce distinct addresses.

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int PAGE_W = 4,
  parameter int ACC_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inc_en,
  input  logic                          tbr_en,
  input  logic                          call_en,
  input  logic                          ret_en,
  input  logic                          pgld_en,
  input  logic                          st_wr,
  input  logic                          st_val,
  input  logic [ACC_W+1:0]              opnd,
  input  logic [ACC_W-1:0]              acc,
  input  logic [3:0]                    breg,
  input  logic                          carry,
  output logic [PAGE_W+ACC_W+1:0]       pc_o,
  output logic                          status_o,
  output logic [DEPTH*(PAGE_W+ACC_W+2)-1:0] stk_o
);
  localparam int ADDR_W = ACC_W + 2;
  localparam int PC_W   = PAGE_W + ADDR_W;

  logic [PAGE_W-1:0] page_q, pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic              status_q;
  logic [PC_W-1:0]   stk_q [DEPTH];

  wire call_go   = call_en & status_q;
  wire call_skip = call_en & ~status_q;
  wire tbr_go    = tbr_en & ~call_en;
  wire ret_go    = ret_en & ~call_en & ~tbr_en;
  wire pgld_go   = pgld_en & ~call_en & ~tbr_en & ~ret_en;
  wire step_go   = (inc_en | pgld_en) & ~call_en & ~tbr_en & ~ret_en;

  wire [PC_W-1:0]   seq_pc   = {page_q, addr_q + ADDR_W'(1)};
  wire [PAGE_W-1:0] tbr_page = {breg[3:2], {(PAGE_W-2){1'b0}}}
                             | PAGE_W'(opnd[1:0]) | PAGE_W'(carry);
  wire [ADDR_W-1:0] tbr_addr = {acc, breg[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      addr_q <= '0;
    end else if (call_go) begin
      page_q <= pend_q;
      addr_q <= opnd;
    end else if (call_skip) begin
      {page_q, addr_q} <= seq_pc;
    end else if (tbr_go) begin
      page_q <= tbr_page;
      addr_q <= tbr_addr;
    end else if (ret_go) begin
      {page_q, addr_q} <= stk_q[0];
    end else if (step_go) begin
      {page_q, addr_q} <= seq_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= '0;
    else if (call_en)  pend_q <= '0;
    else if (pgld_go)  pend_q <= opnd[PAGE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                status_q <= 1'b1;
    else if (call_skip)        status_q <= 1'b1;
    else if (st_wr & ~call_en) status_q <= st_val;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
    logic [PC_W-1:0] push_src, pop_src;
    if (k == 0) begin : g_top
      assign push_src = seq_pc;
    end else begin : g_mid
      assign push_src = stk_q[k-1];
    end
    if (k == DEPTH-1) begin : g_bot
      assign pop_src = stk_q[k];
    end else begin : g_up
      assign pop_src = stk_q[k+1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)       stk_q[k] <= '0;
      else if (call_go) stk_q[k] <= push_src;
      else if (ret_go)  stk_q[k] <= pop_src;
    end
    assign stk_o[k*PC_W +: PC_W] = stk_q[k];
  end

  assign pc_o     = {page_q, addr_q};
  assign status_o = status_q;
endmodule

module prog_seq_chk #(
  parameter int PAGE_W = 4,
  parameter int ACC_W  = 4,
  parameter int DEPTH  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          call_en,
  input logic                          tbr_en,
  input logic                          ret_en,
  input logic [ACC_W+1:0]              opnd,
  input logic [PAGE_W+ACC_W+1:0]       pc_o,
  input logic                          status_o,
  input logic [DEPTH*(PAGE_W+ACC_W+2)-1:0] stk_o
);
  localparam int ADDR_W = ACC_W + 2;
  localparam int PC_W   = PAGE_W + ADDR_W;

  a_r4_tbr_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    (tbr_en && !call_en) |=> status_o == $past(status_o));

  a_r6_skip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (call_en && !status_o) |=> (status_o && stk_o == $past(stk_o)));

  a_r5_call_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (call_en && status_o) |=> pc_o[ADDR_W-1:0] == $past(opnd));

  a_r7_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    (call_en && status_o) |=> stk_o[PC_W-1:0] ==
      $past({pc_o[PC_W-1:ADDR_W], pc_o[ADDR_W-1:0] + ADDR_W'(1)}));

  a_r7_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (call_en && status_o) |=> stk_o[DEPTH*PC_W-1:PC_W] == $past(stk_o[(DEPTH-1)*PC_W-1:0]));

  a_r9_pop_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !call_en && !tbr_en) |=> pc_o == $past(stk_o[PC_W-1:0]));

  a_r9_pop_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !call_en && !tbr_en) |=>
      stk_o[DEPTH*PC_W-1 -: PC_W] == $past(stk_o[DEPTH*PC_W-1 -: PC_W]));
endmodule

bind prog_seq prog_seq_chk #(.PAGE_W(PAGE_W), .ACC_W(ACC_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .call_en(call_en), .tbr_en(tbr_en), .ret_en(ret_en),
  .opnd(opnd), .pc_o(pc_o), .status_o(status_o), .stk_o(stk_o)
);

// File: tb/sim_prog_seq.sv
module sim_prog_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inc_en = 0, tbr_en = 0, call_en = 0, ret_en = 0, pgld_en = 0, st_wr = 0, st_val = 0;
  logic [5:0] opnd = '0;
  logic [3:0] acc = '0, breg = '0;
  logic carry = 1'b0;
  logic [9:0]  pc_o;
  logic        status_o;
  logic [39:0] stk_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_seq u0 (
    .clk(clk), .rst_n(rst_n), .inc_en(inc_en), .tbr_en(tbr_en), .call_en(call_en),
    .ret_en(ret_en), .pgld_en(pgld_en), .st_wr(st_wr), .st_val(st_val), .opnd(opnd),
    .acc(acc), .breg(breg), .carry(carry), .pc_o(pc_o), .status_o(status_o), .stk_o(stk_o)
  );

  // control bits {call, tbr, ret, pgld, inc, st_wr, st_val}
  // entry: ctl[32:26] opnd[25:20] acc[19:16] breg[15:12] carry[11] exp_pc[10:1] exp_st[0]
  localparam logic [32:0] VEC [12] = '{
    {7'b0000100, 6'h00, 4'h0, 4'h0, 1'b0, 10'h001, 1'b1},  // R2
    {7'b0000100, 6'h00, 4'h0, 4'h0, 1'b0, 10'h002, 1'b1},  // R2
    {7'b0100000, 6'h01, 4'hA, 4'hE, 1'b0, 10'h36A, 1'b1},  // R3 R4
    {7'b0000010, 6'h00, 4'h0, 4'h0, 1'b0, 10'h36A, 1'b0},  // R11
    {7'b0100000, 6'h00, 4'h0, 4'h0, 1'b1, 10'h040, 1'b0},  // R3 carry, R4 with flag 0
    {7'b1000000, 6'h15, 4'h0, 4'h0, 1'b0, 10'h041, 1'b1},  // R6 skip
    {7'b0001000, 6'h05, 4'h0, 4'h0, 1'b0, 10'h042, 1'b1},  // R10
    {7'b1000000, 6'h3F, 4'h0, 4'h0, 1'b0, 10'h17F, 1'b1},  // R5 far call, R7
    {7'b0000100, 6'h00, 4'h0, 4'h0, 1'b0, 10'h140, 1'b1},  // R2 wrap
    {7'b1000000, 6'h10, 4'h0, 4'h0, 1'b0, 10'h010, 1'b1},  // R5 pending cleared
    {7'b0010000, 6'h00, 4'h0, 4'h0, 1'b0, 10'h141, 1'b1},  // R9
    {7'b0010000, 6'h00, 4'h0, 4'h0, 1'b0, 10'h043, 1'b1}   // R9
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] ctl, input logic [5:0] op,
                      input logic [3:0] a, input logic [3:0] b, input logic cy);
    @(negedge clk);
    {call_en, tbr_en, ret_en, pgld_en, inc_en, st_wr, st_val} = ctl;
    opnd = op; acc = a; breg = b; carry = cy;
    @(posedge clk);
    #1;
    {call_en, tbr_en, ret_en, pgld_en, inc_en, st_wr, st_val} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1;
    chk(pc_o == 10'h000, "R1 pc", 64'(pc_o), 64'h0);
    chk(status_o == 1'b1, "R1 status", 64'(status_o), 64'h1);
    chk(stk_o == 40'h0, "R1 stack", 64'(stk_o), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][32:26], VEC[i][25:20], VEC[i][19:16], VEC[i][15:12], VEC[i][11]);
      chk(pc_o == VEC[i][10:1], $sformatf("R2-vector %0d pc", i), 64'(pc_o), 64'(VEC[i][10:1]));
      chk(status_o == VEC[i][0], $sformatf("R4-vector %0d status", i), 64'(status_o), 64'(VEC[i][0]));
      if (i == 5) chk(stk_o == 40'h0, "R6 stack untouched by skip", 64'(stk_o), 64'h0);
      if (i == 7) chk(stk_o[9:0] == 10'h043, "R7 pushed return", 64'(stk_o[9:0]), 64'h043);
    end

    // R1 again mid-run, R12 idle hold and precedence
    do_reset();
    step(7'b0000000, 6'h2A, 4'h0, 4'h0, 1'b0);
    chk(pc_o == 10'h000, "R12 idle hold", 64'(pc_o), 64'h0);
    step(7'b1000100, 6'h09, 4'h0, 4'h0, 1'b0);
    chk(pc_o == 10'h009, "R12 call over step", 64'(pc_o), 64'h009);
    step(7'b0110000, 6'h00, 4'h3, 4'h0, 1'b0);
    chk(pc_o == 10'h00C, "R12 branch over return", 64'(pc_o), 64'h00C);

    // R8 overflow and R9 drain past empty
    do_reset();
    for (int i = 1; i <= 5; i++) step(7'b1000000, 6'(i), 4'h0, 4'h0, 1'b0);
    chk(stk_o == {10'd2, 10'd3, 10'd4, 10'd5}, "R8 oldest dropped", 64'(stk_o),
        64'({10'd2, 10'd3, 10'd4, 10'd5}));
    chk(pc_o == 10'd5, "R5 last call target", 64'(pc_o), 64'd5);
    begin
      logic [9:0] exp_pc [5] = '{10'd5, 10'd4, 10'd3, 10'd2, 10'd2};
      for (int i = 0; i < 5; i++) begin
        step(7'b0010000, 6'h00, 4'h0, 4'h0, 1'b0);
        chk(pc_o == exp_pc[i], $sformatf("R9 pop %0d", i), 64'(pc_o), 64'(exp_pc[i]));
      end
    end
    chk(stk_o == {10'd2, 10'd2, 10'd2, 10'd2}, "R9 bottom retained", 64'(stk_o),
        64'({10'd2, 10'd2, 10'd2, 10'd2}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule